// File: doc/BRIEF.md
# Breathing LED Controller with Selectable Period

The block drives a single LED with a pulse-width modulated square wave. The duty cycle climbs one level at a time from fully off to fully on, then descends the same way back to off, and repeats without end. One breath is the time from the LED leaving darkness until it is dark again. Its length is a whole number of seconds between 2 and 10. Brightness is set only by the duty cycle, and each duty level lasts the same time, so the fade has no visible jumps.

The breath length is chosen with raw push buttons. Each button is synchronised to the clock, filtered against bounce, and turned into one pulse per press. A build parameter selects one of two modes. In the first, a single button steps the length upward and wraps from 10 back to 2. In the second, one button raises the length and the other lowers it, and both stop at the limits. A new length takes effect only when the current breath ends in darkness. The duty step time is rescaled to that length, so a breath lasts exactly the selected number of seconds.

Top module: `breath_led_ctrl`

## Requirements
- R1: After reset the applied period output is 2 and the duty level is 0, so the LED output is low for the whole first PWM frame.
- R2: The PWM frame is 2^DUTY_BITS−1 clocks long. In each frame the LED output is high for exactly the current duty level's number of clocks, at the start of the frame. It is never high at level 0 and is high for the whole frame at the top level.
- R3: The duty level starts a breath at 0 and rises by one per step up to the top level. It then falls by one per step back to 0. A breath is 2×(2^DUTY_BITS−1) steps. Each step lasts period × STEP_UNIT whole frames, where STEP_UNIT = CLK_HZ / (2×(2^DUTY_BITS−1)²). A breath therefore lasts period × CLK_HZ clocks when CLK_HZ is a multiple of that divisor.
- R4: In single-button wrap mode (MODE = SEL_WRAP_ONE), each press on `btn_a_raw` adds 1 to the selected period, and a press at 10 gives 2.
- R5: In two-button mode (MODE = SEL_SAT_TWO), a press on `btn_a_raw` adds 1 and a press on `btn_b_raw` subtracts 1. A raise at 10 and a lower at 2 leave the period unchanged, so the period always stays within 2..10.
- R6: A button level counts only after the synchronised input has held the new level for DEB_CYCLES consecutive clocks. Shorter pulses and bounce are ignored.
- R7: A press yields exactly one period change, however long the button is held.
- R8: A selection changes the applied period (`period_s`) only at the clock where the duty level returns to 0 at the end of a breath. Several presses within one breath are applied together.
- R9: In wrap mode the second button has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| btn_a_raw | input | 1 | Raw button: step / raise, active high |
| btn_b_raw | input | 1 | Raw button: lower (two-button mode only), active high |
| led_drive | output | 1 | PWM drive for the LED |
| period_s | output | 4 | Breath period in seconds currently applied |

## Verification
On every cycle, the in-line assertions check these properties:
- the duty level moves by at most one step;
- the direction turns only at full brightness;
- the LED is dark at level 0 and fully lit at the top level;
- the selected period stays within 2..10, wrapping or saturating as the mode requires;
- a press pulse never lasts two cycles;
- the applied period changes only when the duty level is zero.

Other behaviours need the directed scenarios, which compare the LED high time of every frame of whole breaths against a model of the triangle. These are:
- the exact length of a breath after a period change;
- the frame-by-frame brightness profile;
- rejection of short glitches;
- one change per long press;
- the cycle on which a new period appears.

// File: rtl/breath_pkg.sv
package breath_pkg;

    localparam int PERIOD_MIN = 2;
    localparam int PERIOD_MAX = 10;
    localparam int PERIOD_W   = 4;

    typedef logic [PERIOD_W-1:0] period_t;

    typedef enum logic {
        SEL_WRAP_ONE = 1'b0,
        SEL_SAT_TWO  = 1'b1
    } sel_mode_e;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        logic [1:0] sync;
        logic       level;
    } btn_state_t;

    function automatic period_t period_wrap_inc(period_t p);
        return (p >= period_t'(PERIOD_MAX)) ? period_t'(PERIOD_MIN) : p + period_t'(1);
    endfunction

    function automatic period_t period_sat_inc(period_t p);
        return (p >= period_t'(PERIOD_MAX)) ? p : p + period_t'(1);
    endfunction

    function automatic period_t period_sat_dec(period_t p);
        return (p <= period_t'(PERIOD_MIN)) ? p : p - period_t'(1);
    endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner
    import breath_pkg::*;
#(
    parameter int DEB_CYCLES = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    btn_state_t      st_q;
    logic [CW-1:0]   cnt_q;
    logic            press_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            cnt_q   <= '0;
            press_q <= 1'b0;
        end else begin
            st_q.sync <= {st_q.sync[0], raw};
            press_q   <= 1'b0;
            if (st_q.sync[1] == st_q.level) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
                cnt_q      <= '0;
                st_q.level <= st_q.sync[1];
                press_q    <= st_q.sync[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign press = press_q;

    // R7: one press produces a single-cycle pulse
    assert_one_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        press_q |=> !press_q);

    // R6: a pulse only accompanies a filtered level that is now high
    assert_press_level_R6: assert property (@(posedge clk) disable iff (rst)
        press_q |-> st_q.level);

endmodule

// File: rtl/period_select.sv
module period_select
    import breath_pkg::*;
#(
    parameter sel_mode_e MODE = SEL_WRAP_ONE
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    inc,
    input  logic    dec,
    output period_t sel
);
    period_t sel_q;

    generate
        if (MODE == SEL_WRAP_ONE) begin : g_wrap
            always_ff @(posedge clk) begin
                if (rst)      sel_q <= period_t'(PERIOD_MIN);
                else if (inc) sel_q <= period_wrap_inc(sel_q);
            end

            // R4: stepping past the top returns to the bottom
            assert_wrap_to_min_R4: assert property (@(posedge clk) disable iff (rst)
                (inc && sel_q == period_t'(PERIOD_MAX)) |=> sel_q == period_t'(PERIOD_MIN));

            // R9: the second button alone leaves the selection unchanged
            assert_b_ignored_R9: assert property (@(posedge clk) disable iff (rst)
                (dec && !inc) |=> $stable(sel_q));
        end else begin : g_sat
            always_ff @(posedge clk) begin
                if (rst)                sel_q <= period_t'(PERIOD_MIN);
                else if (inc && !dec)   sel_q <= period_sat_inc(sel_q);
                else if (dec && !inc)   sel_q <= period_sat_dec(sel_q);
            end

            // R5: raising at the top is ignored
            assert_hold_top_R5: assert property (@(posedge clk) disable iff (rst)
                (inc && !dec && sel_q == period_t'(PERIOD_MAX)) |=> sel_q == period_t'(PERIOD_MAX));

            // R5: lowering at the bottom is ignored
            assert_hold_bottom_R5: assert property (@(posedge clk) disable iff (rst)
                (dec && !inc && sel_q == period_t'(PERIOD_MIN)) |=> sel_q == period_t'(PERIOD_MIN));
        end
    endgenerate

    assign sel = sel_q;

    // R5: the selection never leaves the legal range
    assert_sel_range_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_q >= period_t'(PERIOD_MIN)) && (sel_q <= period_t'(PERIOD_MAX)));

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
    parameter int DUTY_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DUTY_BITS-1:0] duty,
    output logic                 frame_end,
    output logic                 led
);
    localparam int MAXD = (1 << DUTY_BITS) - 1;

    logic [DUTY_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                                  cnt_q <= '0;
        else if (cnt_q == DUTY_BITS'(MAXD - 1))   cnt_q <= '0;
        else                                      cnt_q <= cnt_q + 1'b1;
    end

    assign frame_end = (cnt_q == DUTY_BITS'(MAXD - 1));
    assign led       = (cnt_q < duty);

endmodule

// File: rtl/breath_ramp.sv
module breath_ramp
    import breath_pkg::*;
#(
    parameter int DUTY_BITS = 8,
    parameter int STEP_UNIT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_end,
    input  period_t              sel,
    output logic [DUTY_BITS-1:0] duty,
    output period_t              active
);
    localparam int MAXD = (1 << DUTY_BITS) - 1;
    localparam int FW   = $clog2(PERIOD_MAX * STEP_UNIT + 1);

    ramp_dir_e            dir_q;
    logic [DUTY_BITS-1:0] duty_q;
    logic [FW-1:0]        fcnt_q;
    period_t              active_q;
    logic [FW-1:0]        step_len;

    assign step_len = FW'(active_q) * FW'(STEP_UNIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= RAMP_UP;
            duty_q   <= '0;
            fcnt_q   <= '0;
            active_q <= period_t'(PERIOD_MIN);
        end else if (frame_end) begin
            if (fcnt_q == step_len - 1'b1) begin
                fcnt_q <= '0;
                if (dir_q == RAMP_UP) begin
                    duty_q <= duty_q + 1'b1;
                    if (duty_q == DUTY_BITS'(MAXD - 1)) dir_q <= RAMP_DOWN;
                end else begin
                    duty_q <= duty_q - 1'b1;
                    if (duty_q == DUTY_BITS'(1)) begin
                        dir_q    <= RAMP_UP;
                        active_q <= sel;
                    end
                end
            end else begin
                fcnt_q <= fcnt_q + 1'b1;
            end
        end
    end

    assign duty   = duty_q;
    assign active = active_q;

    // R3: brightness moves by at most one level per clock
    assert_duty_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_q) |-> (duty_q == $past(duty_q) + DUTY_BITS'(1)) ||
                             (duty_q == $past(duty_q) - DUTY_BITS'(1)));

    // R3: the ramp turns downward only at full brightness
    assert_turn_at_peak_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_q == RAMP_DOWN) |-> duty_q == DUTY_BITS'(MAXD));

    // R8: the applied period changes only in darkness
    assert_apply_dark_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> duty_q == '0);

endmodule

// File: rtl/breath_led_ctrl.sv
module breath_led_ctrl
    import breath_pkg::*;
#(
    parameter int        CLK_HZ     = 100_000_000,
    parameter int        DUTY_BITS  = 8,
    parameter int        DEB_CYCLES = CLK_HZ / 50,
    parameter sel_mode_e MODE       = SEL_WRAP_ONE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_a_raw,
    input  logic       btn_b_raw,
    output logic       led_drive,
    output logic [3:0] period_s
);
    localparam int MAXD      = (1 << DUTY_BITS) - 1;
    localparam int RAW_UNIT  = CLK_HZ / (2 * MAXD * MAXD);
    localparam int STEP_UNIT = (RAW_UNIT < 1) ? 1 : RAW_UNIT;

    logic [1:0]           raw_v;
    logic [1:0]           press_v;
    period_t              sel;
    period_t              active;
    logic [DUTY_BITS-1:0] duty;
    logic                 frame_end;
    logic                 led;

    assign raw_v = {btn_b_raw, btn_a_raw};

    generate
        for (genvar i = 0; i < 2; i++) begin : g_btn
            btn_conditioner #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
                .clk   (clk),
                .rst   (rst),
                .raw   (raw_v[i]),
                .press (press_v[i])
            );
        end
    endgenerate

    period_select #(.MODE(MODE)) u_sel (
        .clk (clk),
        .rst (rst),
        .inc (press_v[0]),
        .dec (press_v[1]),
        .sel (sel)
    );

    breath_ramp #(.DUTY_BITS(DUTY_BITS), .STEP_UNIT(STEP_UNIT)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .sel       (sel),
        .duty      (duty),
        .active    (active)
    );

    pwm_gen #(.DUTY_BITS(DUTY_BITS)) u_pwm (
        .clk       (clk),
        .rst       (rst),
        .duty      (duty),
        .frame_end (frame_end),
        .led       (led)
    );

    assign led_drive = led;
    assign period_s  = active;

    // R2: zero duty keeps the LED dark
    assert_dark_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !led_drive);

    // R2: top duty keeps the LED lit
    assert_lit_at_top_R2: assert property (@(posedge clk) disable iff (rst)
        (duty == DUTY_BITS'(MAXD)) |-> led_drive);

endmodule

// File: tb/test_breath_led_ctrl.sv
module test_breath_led_ctrl;
    import breath_pkg::*;

    localparam int CLK_HZ = 450;
    localparam int DB     = 4;
    localparam int MAXD   = (1 << DB) - 1;
    localparam int UNIT   = CLK_HZ / (2 * MAXD * MAXD);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wa = 1'b0, wb = 1'b0, sa = 1'b0, sb = 1'b0;
    logic       led_w, led_s;
    logic [3:0] per_w, per_s;
    int         n_checks = 0;
    int         n_fail   = 0;
    int         cyc      = 0;
    bit         done     = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    breath_led_ctrl #(.CLK_HZ(CLK_HZ), .DUTY_BITS(DB), .MODE(SEL_WRAP_ONE)) i_breath_led_ctrl (
        .clk(clk), .rst(rst), .btn_a_raw(wa), .btn_b_raw(wb),
        .led_drive(led_w), .period_s(per_w));

    breath_led_ctrl #(.CLK_HZ(CLK_HZ), .DUTY_BITS(DB), .MODE(SEL_SAT_TWO)) i_breath_led_ctrl_sat (
        .clk(clk), .rst(rst), .btn_a_raw(sa), .btn_b_raw(sb),
        .led_drive(led_s), .period_s(per_s));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int per_of(input bit sat);
        return sat ? int'(per_s) : int'(per_w);
    endfunction

    function automatic bit led_of(input bit sat);
        return sat ? led_s : led_w;
    endfunction

    task automatic drive_btn(input bit sat, input bit which, input bit v);
        if (sat) begin
            if (which) sb = v; else sa = v;
        end else begin
            if (which) wb = v; else wa = v;
        end
    endtask

    task automatic press(input bit sat, input bit which, input int hold);
        drive_btn(sat, which, 1'b1);
        repeat (hold) @(negedge clk);
        drive_btn(sat, which, 1'b0);
        repeat (25) @(negedge clk);
    endtask

    task automatic wait_period(input bit sat, input int val, input int limit, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (per_of(sat) == val) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Compares the high time of every frame of one breath against the triangle model
    task automatic measure_breath(input bit sat, input int p, input string req);
        int bad = 0, first_f = -1, first_act = 0, first_exp = 0;
        for (int f = 0; f < p * UNIT * 2 * MAXD; f++) begin
            int s   = f / (p * UNIT);
            int exp = (s <= MAXD) ? s : 2 * MAXD - s;
            int hi  = 0;
            for (int k = 0; k < MAXD; k++) begin
                hi += int'(led_of(sat));
                @(negedge clk);
            end
            if (hi != exp) begin
                if (first_f < 0) begin
                    first_f = f; first_act = hi; first_exp = exp;
                end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("frame %0d high clocks (period %0d)", first_f, p),
              first_act, first_exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        check(per_w == 4'd2, "R1", "wrap period after reset", per_w, 2);
        check(per_s == 4'd2, "R1", "sat period after reset", per_s, 2);
        check(led_w == 1'b0, "R1", "wrap led after reset", led_w, 0);
        check(led_s == 1'b0, "R1", "sat led after reset", led_s, 0);
    endtask

    task automatic t_profile_two();
        // R1 R2 R3: first breath from reset at 2 s
        measure_breath(1'b0, 2, "R2,R3");
    endtask

    task automatic t_apply_on_dark();
        int t0 = cyc;
        bit ok;
        press(1'b0, 1'b0, 20);
        check(per_w == 4'd2, "R8", "period before breath end", per_w, 2);
        wait_period(1'b0, 3, 1000, ok);
        check(ok, "R4", "period after one press", per_w, 3);
        check(cyc - t0 == 2 * CLK_HZ, "R8", "cycle of period change", cyc - t0, 2 * CLK_HZ);
        measure_breath(1'b0, 3, "R3");
    endtask

    task automatic t_wrap_cycle();
        int t0 = cyc;
        bit ok;
        for (int i = 0; i < 7; i++) press(1'b0, 1'b0, 20);
        check(per_w == 4'd3, "R8", "presses not applied mid-breath", per_w, 3);
        wait_period(1'b0, 10, 2000, ok);
        check(ok, "R8", "seven presses applied together", per_w, 10);
        check(cyc - t0 == 3 * CLK_HZ, "R8", "cycle of period change", cyc - t0, 3 * CLK_HZ);
        press(1'b0, 1'b0, 20);
        wait_period(1'b0, 2, 5000, ok);
        check(ok, "R4", "wrap from 10", per_w, 2);
    endtask

    task automatic t_glitch();
        for (int i = 0; i < 3; i++) begin
            wa = 1'b1; repeat (4) @(negedge clk);
            wa = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (1000) @(negedge clk);
        check(per_w == 4'd2, "R6", "short pulses ignored", per_w, 2);
        for (int i = 0; i < 3; i++) begin
            wa = 1'b1; repeat (2) @(negedge clk);
            wa = 1'b0; repeat (2) @(negedge clk);
        end
        press(1'b0, 1'b0, 20);
        repeat (1000) @(negedge clk);
        check(per_w == 4'd3, "R6", "bouncy press counted once", per_w, 3);
    endtask

    task automatic t_long_hold();
        press(1'b0, 1'b0, 300);
        repeat (1400) @(negedge clk);
        check(per_w == 4'd4, "R7", "long hold single step", per_w, 4);
    endtask

    task automatic t_b_ignored();
        press(1'b0, 1'b1, 20);
        repeat (4 * CLK_HZ + 100) @(negedge clk);
        check(per_w == 4'd4, "R9", "second button in wrap mode", per_w, 4);
    endtask

    task automatic t_sat_floor();
        press(1'b1, 1'b1, 20);
        repeat (1000) @(negedge clk);
        check(per_s == 4'd2, "R5", "lower at 2 ignored", per_s, 2);
    endtask

    task automatic t_sat_range();
        bit ok;
        for (int i = 0; i < 9; i++) press(1'b1, 1'b0, 20);
        wait_period(1'b1, 10, 3000, ok);
        check(ok, "R5", "raise to 10", per_s, 10);
        press(1'b1, 1'b0, 20);
        press(1'b1, 1'b0, 20);
        repeat (10 * CLK_HZ + 100) @(negedge clk);
        check(per_s == 4'd10, "R5", "raise at 10 ignored", per_s, 10);
        press(1'b1, 1'b1, 20);
        press(1'b1, 1'b1, 20);
        wait_period(1'b1, 8, 5000, ok);
        check(ok, "R5", "lower twice from 10", per_s, 8);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_profile_two();
        t_apply_on_dark();
        t_wrap_cycle();
        t_glitch();
        t_long_hold();
        t_b_ignored();
        t_sat_floor();
        t_sat_range();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule